// File: doc/BRIEF.md
# Register-Transfer Control Sequencer

This block is the master of a shared register bus. Peripheral modules sit behind that bus and each one owns a small window of register addresses. Each module can raise a service-request line. When a request arrives, the sequencer reads one register from the requesting module, then writes the captured value into a register of another module. This chain of a read and a write is one transfer. A small table, writable at any time, holds the source register offset and the full destination address for each channel. A local kick input lets the controlling logic queue a transfer for a channel without a request line.

The bus signals all run in one direction, with no tri-state drivers. Each read ends with a one-cycle `bus_rd` strobe, and the sequencer only issues it after the addressed module reports `bus_rdy`. Each write ends with a one-cycle `bus_wr` strobe, and the sequencer only issues it after `bus_busy` is seen low. A watchdog limits how long a read may wait for `bus_rdy`. When it expires, the read is abandoned, no write takes place, and a sticky error flag is set.

Top module: `xfer_seq`

## Requirements
- R1: While reset is active and at its release, `bus_rd`, `bus_wr` and `err_timeout` are low. `bus_addr` and `bus_wdata` are zero, and every table entry is zero.
- R2: With the sequencer idle and `svc_req[i]` high at a clock edge, the sequencer drives `bus_addr = {i, src_off[i]}` from the next cycle on. With 4 channels and 2 offset bits this equals i*4 + src_off[i]. `bus_rd` stays low until `bus_rdy` is sampled high.
- R3: The first edge at which `bus_rdy` is sampled high during the read wait captures `bus_rdata`. `bus_rd` is then high for exactly the next cycle, and `bus_addr` holds the source address during that cycle.
- R4: In the cycle after the `bus_rd` strobe, `bus_addr` becomes `dst_addr[i]` and `bus_wdata` carries the captured value. `bus_wr` goes high for one cycle, in the cycle after the first edge that samples `bus_busy` low in this phase. Address and data stay unchanged through the strobe.
- R5: `bus_rd` and `bus_wr` are never high together. Each is high for one cycle per transfer.
- R6: Pending channels are served lowest index first, one whole transfer at a time. After the `bus_wr` cycle the sequencer spends one idle cycle before the next grant. Requests that arrive during a transfer wait for it to finish.
- R7: If `bus_rdy` is not sampled high on any of 16 consecutive read-wait edges, the read is abandoned. No `bus_rd` and no `bus_wr` follow. `err_timeout` rises in the next cycle and stays high until reset. A `bus_rdy` sampled on the 16th edge still completes the read.
- R8: A one-cycle `kick_valid` pulse queues a transfer for channel `kick_chan`. It is served like a request line, even if the pulse falls during another transfer. The queued entry is cleared when it is granted, so it produces exactly one transfer.
- R9: A `tbl_we` cycle stores `tbl_src` and `tbl_dst` into entry `tbl_idx`. Every transfer granted after that cycle uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| svc_req | input | N_CHAN | Per-channel read-service request lines (level) |
| kick_valid | input | 1 | One-cycle pulse that queues a transfer |
| kick_chan | input | CHAN_W | Channel queued by `kick_valid` |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | CHAN_W | Table entry to write |
| tbl_src | input | REG_W | Source register offset inside the channel's window |
| tbl_dst | input | ADDR_W | Full destination register address |
| bus_addr | output | ADDR_W | Bus register address |
| bus_wdata | output | DATA_W | Write data driven to modules |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rdata | input | DATA_W | Read data from the addressed module |
| bus_rdy | input | 1 | Addressed module has read data ready |
| bus_busy | input | 1 | Addressed module is using the target register |
| err_timeout | output | 1 | Sticky read-timeout flag |

## Verification
The properties assume only that `bus_rdy`, `bus_busy` and `bus_rdata` are synchronous to `clk`. They do not assume that a module answers at all, and that is why the timeout path exists. The stimulus changes every input on the falling edge. It raises `bus_rdy` for a single cycle with `bus_rdata` valid in that cycle, and replaces the data straight after, so the capture point is exposed. It holds `bus_busy` high for a counted number of write-wait edges. Request and kick lines are dropped as soon as their grant is seen, so each channel produces exactly the transfers the bench expects.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_RD_WAIT = 3'd1,
    SQ_RD_STB  = 3'd2,
    SQ_WR_WAIT = 3'd3,
    SQ_WR_STB  = 3'd4
  } sq_state_t;
endpackage

// File: rtl/xfer_pick.sv
module xfer_pick #(
  parameter int N_CHAN = 4,
  localparam int CHAN_W = $clog2(N_CHAN)
) (
  input  logic [N_CHAN-1:0] want,
  output logic [N_CHAN-1:0] grant_oh,
  output logic [CHAN_W-1:0] grant_idx,
  output logic              grant_any
);
  // Scan from the top down so the lowest set bit is the last one to win.
  always_comb begin
    grant_oh  = '0;
    grant_idx = '0;
    for (int i = N_CHAN - 1; i >= 0; i--) begin
      if (want[i]) begin
        grant_oh    = '0;
        grant_oh[i] = 1'b1;
        grant_idx   = CHAN_W'(i);
      end
    end
    grant_any = |want;
  end
endmodule

// File: rtl/xfer_route_tbl.sv
module xfer_route_tbl #(
  parameter int N_CHAN = 4,
  parameter int REG_W  = 2,
  localparam int CHAN_W = $clog2(N_CHAN),
  localparam int ADDR_W = CHAN_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CHAN_W-1:0] widx,
  input  logic [REG_W-1:0]  wsrc,
  input  logic [ADDR_W-1:0] wdst,
  input  logic [CHAN_W-1:0] ridx,
  output logic [REG_W-1:0]  rsrc,
  output logic [ADDR_W-1:0] rdst
);
  logic [REG_W-1:0]  src_q [N_CHAN];
  logic [ADDR_W-1:0] dst_q [N_CHAN];

  for (genvar g = 0; g < N_CHAN; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g] <= '0;
        dst_q[g] <= '0;
      end else if (we && widx == CHAN_W'(g)) begin
        src_q[g] <= wsrc;
        dst_q[g] <= wdst;
      end
    end
  end

  assign rsrc = src_q[ridx];
  assign rdst = dst_q[ridx];
endmodule

// File: rtl/xfer_rdy_timer.sv
module xfer_rdy_timer #(
  parameter int LIMIT = 16,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign expire = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int N_CHAN  = 4,
  parameter int REG_W   = 2,
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 16,
  localparam int CHAN_W = $clog2(N_CHAN),
  localparam int ADDR_W = CHAN_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CHAN-1:0] svc_req,
  input  logic              kick_valid,
  input  logic [CHAN_W-1:0] kick_chan,
  input  logic              tbl_we,
  input  logic [CHAN_W-1:0] tbl_idx,
  input  logic [REG_W-1:0]  tbl_src,
  input  logic [ADDR_W-1:0] tbl_dst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy,
  input  logic              bus_busy,
  output logic              err_timeout
);
  sq_state_t         state_q;
  logic [CHAN_W-1:0] chan_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;
  logic [N_CHAN-1:0] kick_pend_q;

  logic [N_CHAN-1:0] kick_vec;
  logic [N_CHAN-1:0] want;
  logic [N_CHAN-1:0] grant_oh;
  logic [CHAN_W-1:0] grant_idx;
  logic              grant_any;
  logic [CHAN_W-1:0] tbl_ridx;
  logic [REG_W-1:0]  rt_src;
  logic [ADDR_W-1:0] rt_dst;
  logic              rdy_expire;
  logic              in_idle;

  assign in_idle  = (state_q == SQ_IDLE);
  assign kick_vec = kick_valid ? (N_CHAN'(1) << kick_chan) : '0;
  assign want     = svc_req | kick_pend_q | kick_vec;
  // The table is read for the source while idle, and for the destination afterwards.
  assign tbl_ridx = in_idle ? grant_idx : chan_q;

  xfer_pick #(.N_CHAN(N_CHAN)) u_pick (
    .want      (want),
    .grant_oh  (grant_oh),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  xfer_route_tbl #(.N_CHAN(N_CHAN), .REG_W(REG_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .widx  (tbl_idx),
    .wsrc  (tbl_src),
    .wdst  (tbl_dst),
    .ridx  (tbl_ridx),
    .rsrc  (rt_src),
    .rdst  (rt_dst)
  );

  xfer_rdy_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == SQ_RD_WAIT),
    .expire (rdy_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      chan_q      <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      err_q       <= 1'b0;
      kick_pend_q <= '0;
    end else begin
      kick_pend_q <= kick_pend_q | kick_vec;
      unique case (state_q)
        SQ_IDLE: begin
          if (grant_any) begin
            chan_q      <= grant_idx;
            addr_q      <= {grant_idx, rt_src};
            kick_pend_q <= (kick_pend_q | kick_vec) & ~grant_oh;
            state_q     <= SQ_RD_WAIT;
          end
        end
        SQ_RD_WAIT: begin
          if (bus_rdy) begin
            data_q  <= bus_rdata;
            state_q <= SQ_RD_STB;
          end else if (rdy_expire) begin
            err_q   <= 1'b1;
            state_q <= SQ_IDLE;
          end
        end
        SQ_RD_STB: begin
          addr_q  <= rt_dst;
          state_q <= SQ_WR_WAIT;
        end
        SQ_WR_WAIT: begin
          if (!bus_busy) state_q <= SQ_WR_STB;
        end
        SQ_WR_STB: begin
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_addr    = addr_q;
  assign bus_wdata   = data_q;
  assign bus_rd      = (state_q == SQ_RD_STB);
  assign bus_wr      = (state_q == SQ_WR_STB);
  assign err_timeout = err_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_rdy,
  input logic              bus_busy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              err_timeout
);
  // R5: the two strobes never overlap
  a_r5_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R5: each strobe lasts one cycle
  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);

  // R3: a read strobe follows a sampled rdy, with the address held
  a_r3_rd_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> ($past(bus_rdy) && $stable(bus_addr)));

  // R4: a write strobe follows a sampled low busy, with address and data held
  a_r4_wr_after_idle_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (!$past(bus_busy) && $stable(bus_addr) && $stable(bus_wdata)));

  // R7: the timeout flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout);
endmodule

bind xfer_seq xfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rdy     (bus_rdy),
  .bus_busy    (bus_busy),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .err_timeout (err_timeout)
);

// File: tb/tb_xfer_seq.sv
`timescale 1ns/1ps
module tb_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  svc_req = '0;
  logic        kick_valid = 1'b0;
  logic [1:0]  kick_chan = '0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_idx = '0;
  logic [1:0]  tbl_src = '0;
  logic [3:0]  tbl_dst = '0;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_rdata = '0;
  logic        bus_rdy = 1'b0;
  logic        bus_busy = 1'b0;
  logic        err_timeout;

  int n_chk = 0;
  int n_fail = 0;
  int src_m [4];
  int dst_m [4];

  always #4 clk = ~clk;

  xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .svc_req(svc_req),
    .kick_valid(kick_valid), .kick_chan(kick_chan),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_src(tbl_src), .tbl_dst(tbl_dst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .bus_busy(bus_busy),
    .err_timeout(err_timeout)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tbl_write(int idx, int src, int dst);
    tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_src = 2'(src); tbl_dst = 4'(dst);
    src_m[idx] = src; dst_m[idx] = dst;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // One transfer on channel ch, called at a falling edge while the sequencer is idle.
  task automatic xfer(int ch, bit raise, int lat, int bsy, logic [15:0] val);
    if (raise) svc_req[ch] = 1'b1;
    @(negedge clk);
    kick_valid = 1'b0;
    svc_req[ch] = 1'b0;
    chk("R2 source address", 32'(bus_addr), 32'(ch * 4 + src_m[ch]));
    chk("R2 no rd before rdy", 32'(bus_rd), 0);
    chk("R5 no wr during read", 32'(bus_wr), 0);
    repeat (lat) begin
      @(negedge clk);
      chk("R3 rd waits for rdy", 32'(bus_rd), 0);
    end
    bus_rdy = 1'b1; bus_rdata = val;
    @(negedge clk);
    chk("R3 rd strobe", 32'(bus_rd), 1);
    chk("R3 address held at rd", 32'(bus_addr), 32'(ch * 4 + src_m[ch]));
    chk("R5 no wr with rd", 32'(bus_wr), 0);
    bus_rdy = 1'b0; bus_rdata = ~val; bus_busy = (bsy > 0);
    @(negedge clk);
    chk("R5 rd one cycle", 32'(bus_rd), 0);
    chk("R4 destination address", 32'(bus_addr), 32'(dst_m[ch]));
    chk("R3 captured data", 32'(bus_wdata), 32'(val));
    chk("R4 wr waits", 32'(bus_wr), 0);
    repeat (bsy) begin
      @(negedge clk);
      chk("R4 wr held off by busy", 32'(bus_wr), 0);
    end
    bus_busy = 1'b0;
    @(negedge clk);
    chk("R4 wr strobe", 32'(bus_wr), 1);
    chk("R4 address at wr", 32'(bus_addr), 32'(dst_m[ch]));
    chk("R4 data at wr", 32'(bus_wdata), 32'(val));
    chk("R5 no rd with wr", 32'(bus_rd), 0);
    @(negedge clk);
    chk("R5 wr one cycle", 32'(bus_wr), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) begin src_m[i] = 0; dst_m[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1 rd in reset", 32'(bus_rd), 0);
    chk("R1 wr in reset", 32'(bus_wr), 0);
    chk("R1 err in reset", 32'(err_timeout), 0);
    chk("R1 addr in reset", 32'(bus_addr), 0);
    chk("R1 wdata in reset", 32'(bus_wdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 32'({bus_rd, bus_wr, err_timeout}), 0);

    // R1: zero table until programmed (channel 2 reads offset 0, writes address 0)
    xfer(2, 1'b1, 0, 0, 16'h1234);

    for (int i = 0; i < 4; i++) tbl_write(i, (i + 1) % 4, ((i + 2) % 4) * 4 + i);

    // R2 R3 R4: sweep of channel, rdy latency 0..15 and busy length 0..3
    for (int ch = 0; ch < 4; ch++)
      for (int lat = 0; lat < 16; lat++)
        for (int b = 0; b < 4; b++)
          xfer(ch, 1'b1, lat, b, 16'((ch << 12) | (lat << 8) | (b << 4) | 5));

    // R6: lowest index first, one transfer at a time
    svc_req = 4'b1010;
    xfer(1, 1'b0, 2, 1, 16'hB001);
    xfer(3, 1'b0, 0, 0, 16'hB003);
    svc_req = 4'b1111;
    for (int ch = 0; ch < 4; ch++) xfer(ch, 1'b0, 1, ch, 16'(16'hC000 + ch));

    // R8: kick queued behind a request, served once
    svc_req[1] = 1'b1; kick_valid = 1'b1; kick_chan = 2'd2;
    xfer(1, 1'b0, 3, 0, 16'hD001);
    xfer(2, 1'b0, 0, 2, 16'hD002);
    repeat (4) begin
      @(negedge clk);
      chk("R8 kick served once (addr)", 32'(bus_addr), 32'(dst_m[2]));
      chk("R8 kick served once (rd)", 32'(bus_rd), 0);
    end
    // R8: kick alone
    kick_valid = 1'b1; kick_chan = 2'd3;
    xfer(3, 1'b0, 5, 1, 16'hD003);

    // R9: reprogrammed entry used by the next transfer
    tbl_write(1, 3, 4'hE);
    xfer(1, 1'b1, 1, 1, 16'hE111);

    // R7: no rdy for 16 edges aborts the read
    svc_req[2] = 1'b1;
    @(negedge clk);
    svc_req[2] = 1'b0;
    chk("R7 read started", 32'(bus_addr), 32'(2 * 4 + src_m[2]));
    repeat (15) begin
      @(negedge clk);
      chk("R7 no rd while waiting", 32'(bus_rd), 0);
    end
    chk("R7 err before limit", 32'(err_timeout), 0);
    @(negedge clk);
    chk("R7 err set", 32'(err_timeout), 1);
    repeat (4) begin
      chk("R7 no strobe after abort", 32'({bus_rd, bus_wr}), 0);
      chk("R7 no write phase", 32'(bus_addr), 32'(2 * 4 + src_m[2]));
      @(negedge clk);
    end
    xfer(0, 1'b1, 4, 1, 16'hF00D);
    chk("R7 err sticky", 32'(err_timeout), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule